// File: doc/BRIEF.md
# Retire-Cycle Sample Metadata Capture

This block sits beside the retire stage of a multi-wide core and records what the retire stage was doing in the cycle when a sampling strobe fires. Each cycle it sees a bundle of `W` retire slots. Slot 0 holds the oldest instruction. Each slot carries a valid flag, a taken-control-transfer flag (this covers branches, jumps, interrupts and exceptions), the destination address of that transfer, and a vector of performance-event bits. The block also receives three status lines from the retire stage: stall, drained and flush.

When the strobe is high, the block freezes three registers:

- a details word that packs the transfer count, the positions of the first two transfers, a 2-bit retire state, the position of the instruction blamed for lost retire bandwidth, and that instruction's event bits;
- two target registers that hold the destinations of the first two transfers.

Profiling software reads these registers through a small CSR port. It uses them to walk the retired group instruction by instruction and to split the sampled cycle across the instructions that retired. It also builds per-instruction cycle stacks from the retire state and the event bits.

Top module: `retire_sample_capture`

## Requirements
- R1: The retired group is the unbroken run of valid slots that starts at slot 0. A valid slot that follows an invalid slot is not retired and has no effect on any captured field.
- R2: Details bits [4:2] capture the number of taken transfers in the retired group. The count saturates at 7.
- R3: Details bits [7:5] capture the 1-based slot position of the first taken transfer, and target register 1 captures its destination. Bits [10:8] and target register 2 do the same for the second transfer. A transfer that is absent leaves its position field and its target register at zero. A third or later transfer only increments the count.
- R4: Details bits [1:0] capture the retire state, encoded 00 retiring, 01 stalling, 10 drained, 11 flushed. The state is 00 whenever at least one slot retires.
- R5: When no slot retires, the state follows the priority flush over drained over stall. With none of the three status lines high, the state is drained.
- R6: Details bits [13:11] capture the blame position. If the retired count n is below `W` and the state is not drained, the position is n+1. This points to the oldest instruction when n is 0, and otherwise to the first instruction that did not retire. In every other case the position is 0.
- R7: Details bits [21:14] capture the event vector of the blamed slot. They are 0 when the blame position is 0.
- R8: The three registers load only on a cycle with the strobe high. On any other cycle they hold their values unless a CSR write targets them.
- R9: CSR select codes are: 0 = details, 1 = target 1, 2 = target 2, 3 = unmapped. The read data is combinational. A write is visible from the next cycle. Details bits [63:22] always read 0. Select 3 reads 0, and a write to it changes nothing.
- R10: When a CSR write and the strobe occur in the same cycle, the captured values win.
- R11: After reset, all three registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_vld | input | W | Per-slot valid; bit 0 is the oldest slot |
| slot_taken | input | W | Per-slot taken-control-transfer flag |
| slot_tgt | input | W*XLEN | Per-slot transfer destination; slot i occupies bits [i*XLEN +: XLEN] |
| slot_evt | input | W*EVW | Per-slot event bits; slot i occupies bits [i*EVW +: EVW] |
| rs_stall | input | 1 | Retire stage is stalled |
| rs_drained | input | 1 | Pipeline is empty |
| rs_flush | input | 1 | Pipeline is being flushed |
| smp_strobe | input | 1 | Sample strobe; capture happens in this cycle |
| csr_sel | input | 2 | Register select |
| csr_we | input | 1 | Write enable |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data for the selected register |

## Verification
The main sweep runs every combination of valid pattern, taken pattern and status lines for a four-slot bundle. That is 2048 captures.

- Gapped valid patterns separate a correct leading-run detector from one that counts every valid bit.
- Groups with three or four taken slots show whether only the first two targets are kept.
- Captures with an empty group under each mix of status lines pin down the state priority and the drained rule for blame.

After each capture, the inputs are scrambled for one cycle with the strobe low, which exposes any capture without a strobe. Directed sequences then cover the write mask, the unmapped select and a write that collides with a strobe.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  typedef enum logic [1:0] {
    RS_RETIRE = 2'b00,
    RS_STALL  = 2'b01,
    RS_DRAIN  = 2'b10,
    RS_FLUSH  = 2'b11
  } rstate_e;

  // Classify the retire stage for one cycle.
  function automatic rstate_e classify(input logic any_ret, input logic flush,
                                       input logic drained, input logic stall);
    if (any_ret)      return RS_RETIRE;
    else if (flush)   return RS_FLUSH;
    else if (drained) return RS_DRAIN;
    else if (stall)   return RS_STALL;
    else              return RS_DRAIN;
  endfunction

endpackage

// File: rtl/rsc_retire_run.sv
module rsc_retire_run #(
  parameter int W  = 4,
  parameter int OW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vld,
  output logic [W-1:0]  run,
  output logic [OW-1:0] n
);
  always_comb begin
    logic alive;
    alive = 1'b1;
    n     = '0;
    for (int i = 0; i < W; i++) begin
      alive  = alive & vld[i];
      run[i] = alive;
      if (alive) n = n + OW'(1);
    end
  end
endmodule

// File: rtl/rsc_ct_scan.sv
module rsc_ct_scan #(
  parameter int W    = 4,
  parameter int XLEN = 64,
  parameter int OW   = $clog2(W + 1)
) (
  input  logic [W-1:0]      run,
  input  logic [W-1:0]      taken,
  input  logic [W*XLEN-1:0] tgt,
  output logic [OW-1:0]     cnt,
  output logic [OW-1:0]     off1,
  output logic [OW-1:0]     off2,
  output logic [XLEN-1:0]   tgt1,
  output logic [XLEN-1:0]   tgt2
);
  // Scan oldest to youngest; keep the first two destinations.
  always_comb begin
    cnt  = '0;
    off1 = '0;
    off2 = '0;
    tgt1 = '0;
    tgt2 = '0;
    for (int i = 0; i < W; i++) begin
      if (run[i] && taken[i]) begin
        if (cnt == OW'(0)) begin
          off1 = OW'(i + 1);
          tgt1 = tgt[i*XLEN +: XLEN];
        end else if (cnt == OW'(1)) begin
          off2 = OW'(i + 1);
          tgt2 = tgt[i*XLEN +: XLEN];
        end
        if (cnt != '1) cnt = cnt + OW'(1);
      end
    end
  end
endmodule

// File: rtl/rsc_blame.sv
module rsc_blame
  import rsc_pkg::*;
#(
  parameter int W   = 4,
  parameter int EVW = 8,
  parameter int OW  = $clog2(W + 1)
) (
  input  logic [OW-1:0]    ret_n,
  input  logic [W*EVW-1:0] evt,
  input  logic             flush,
  input  logic             drained,
  input  logic             stall,
  output rstate_e          rstate,
  output logic [OW-1:0]    boff,
  output logic [EVW-1:0]   cause
);
  always_comb begin
    rstate = classify(ret_n != '0, flush, drained, stall);
    boff   = '0;
    cause  = '0;
    if (ret_n < OW'(W) && rstate != RS_DRAIN) begin
      boff = ret_n + OW'(1);
      for (int i = 0; i < W; i++)
        if (ret_n == OW'(i)) cause = evt[i*EVW +: EVW];
    end
  end
endmodule

// File: rtl/rsc_regs.sv
module rsc_regs #(
  parameter int              XLEN     = 64,
  parameter logic [XLEN-1:0] DET_MASK = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap,
  input  logic [XLEN-1:0] det_new,
  input  logic [XLEN-1:0] t1_new,
  input  logic [XLEN-1:0] t2_new,
  input  logic            we,
  input  logic [1:0]      sel,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] det_q,
  output logic [XLEN-1:0] t1_q,
  output logic [XLEN-1:0] t2_q,
  output logic [XLEN-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      det_q <= '0;
      t1_q  <= '0;
      t2_q  <= '0;
    end else if (cap) begin
      det_q <= det_new & DET_MASK;
      t1_q  <= t1_new;
      t2_q  <= t2_new;
    end else if (we) begin
      case (sel)
        2'd0:    det_q <= wdata & DET_MASK;
        2'd1:    t1_q  <= wdata;
        2'd2:    t2_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      2'd0:    rdata = det_q;
      2'd1:    rdata = t1_q;
      2'd2:    rdata = t2_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/retire_sample_capture.sv
module retire_sample_capture
  import rsc_pkg::*;
#(
  parameter int W    = 4,
  parameter int XLEN = 64,
  parameter int EVW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      slot_vld,
  input  logic [W-1:0]      slot_taken,
  input  logic [W*XLEN-1:0] slot_tgt,
  input  logic [W*EVW-1:0]  slot_evt,
  input  logic              rs_stall,
  input  logic              rs_drained,
  input  logic              rs_flush,
  input  logic              smp_strobe,
  input  logic [1:0]        csr_sel,
  input  logic              csr_we,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata
);
  localparam int OW      = $clog2(W + 1);
  localparam int RS_LSB  = 0;
  localparam int CNT_LSB = 2;
  localparam int OF1_LSB = CNT_LSB + OW;
  localparam int OF2_LSB = OF1_LSB + OW;
  localparam int BLM_LSB = OF2_LSB + OW;
  localparam int CAU_LSB = BLM_LSB + OW;
  localparam int USED    = CAU_LSB + EVW;
  localparam logic [XLEN-1:0] DET_MASK =
    ({{(XLEN-1){1'b0}}, 1'b1} << USED) - 1'b1;

  // Named internal events
  logic [W-1:0]    ret_run;
  logic [OW-1:0]   ret_n;
  logic [OW-1:0]   cap_cnt, cap_off1, cap_off2, cap_boff;
  logic [XLEN-1:0] cap_tgt1, cap_tgt2;
  rstate_e         cap_rstate;
  logic [EVW-1:0]  cap_cause;
  logic [XLEN-1:0] cap_det;
  logic [XLEN-1:0] det_q, t1_q, t2_q;

  rsc_retire_run #(.W(W), .OW(OW)) u_run (
    .vld (slot_vld),
    .run (ret_run),
    .n   (ret_n)
  );

  rsc_ct_scan #(.W(W), .XLEN(XLEN), .OW(OW)) u_scan (
    .run   (ret_run),
    .taken (slot_taken),
    .tgt   (slot_tgt),
    .cnt   (cap_cnt),
    .off1  (cap_off1),
    .off2  (cap_off2),
    .tgt1  (cap_tgt1),
    .tgt2  (cap_tgt2)
  );

  rsc_blame #(.W(W), .EVW(EVW), .OW(OW)) u_blame (
    .ret_n   (ret_n),
    .evt     (slot_evt),
    .flush   (rs_flush),
    .drained (rs_drained),
    .stall   (rs_stall),
    .rstate  (cap_rstate),
    .boff    (cap_boff),
    .cause   (cap_cause)
  );

  always_comb begin
    cap_det = '0;
    cap_det[RS_LSB  +: 2]   = cap_rstate;
    cap_det[CNT_LSB +: OW]  = cap_cnt;
    cap_det[OF1_LSB +: OW]  = cap_off1;
    cap_det[OF2_LSB +: OW]  = cap_off2;
    cap_det[BLM_LSB +: OW]  = cap_boff;
    cap_det[CAU_LSB +: EVW] = cap_cause;
  end

  rsc_regs #(.XLEN(XLEN), .DET_MASK(DET_MASK)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (smp_strobe),
    .det_new (cap_det),
    .t1_new  (cap_tgt1),
    .t2_new  (cap_tgt2),
    .we      (csr_we),
    .sel     (csr_sel),
    .wdata   (csr_wdata),
    .det_q   (det_q),
    .t1_q    (t1_q),
    .t2_q    (t2_q),
    .rdata   (csr_rdata)
  );
endmodule

// File: rtl/rsc_chk.sv
module rsc_chk #(
  parameter int W    = 4,
  parameter int XLEN = 64,
  parameter int EVW  = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            smp_strobe,
  input logic            csr_we,
  input logic [1:0]      csr_sel,
  input logic [XLEN-1:0] csr_wdata,
  input logic            rs_flush,
  input logic [W-1:0]    slot_vld,
  input logic [$clog2(W+1)-1:0] ret_n,
  input logic [XLEN-1:0] det_q,
  input logic [XLEN-1:0] t1_q,
  input logic [XLEN-1:0] t2_q
);
  localparam int OW      = $clog2(W + 1);
  localparam int CNT_LSB = 2;
  localparam int OF1_LSB = CNT_LSB + OW;
  localparam int OF2_LSB = OF1_LSB + OW;
  localparam int BLM_LSB = OF2_LSB + OW;
  localparam int USED    = BLM_LSB + OW + EVW;

  // R4
  retire_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_strobe && slot_vld[0] |=> det_q[1:0] == 2'b00);
  // R5
  flush_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_strobe && !slot_vld[0] && rs_flush |=> det_q[1:0] == 2'b11);
  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_strobe |=> det_q[CNT_LSB +: OW] <= $past(ret_n));
  // R3
  offset_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_strobe |=> (det_q[OF2_LSB +: OW] == '0) ||
                   (det_q[OF2_LSB +: OW] > det_q[OF1_LSB +: OW]));
  // R6
  full_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_strobe && (&slot_vld) |=> det_q[BLM_LSB +: OW] == '0);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_strobe && !csr_we |=> $stable(det_q) && $stable(t1_q) && $stable(t2_q));
  // R9
  write_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we && !smp_strobe && csr_sel == 2'd1 |=> t1_q == $past(csr_wdata));
  // R9
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    det_q[XLEN-1:USED] == '0);
  // R9
  sel3_noeffect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we && !smp_strobe && csr_sel == 2'd3 |=> $stable(det_q) && $stable(t1_q) && $stable(t2_q));
endmodule

bind retire_sample_capture rsc_chk #(.W(W), .XLEN(XLEN), .EVW(EVW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_strobe (smp_strobe),
  .csr_we     (csr_we),
  .csr_sel    (csr_sel),
  .csr_wdata  (csr_wdata),
  .rs_flush   (rs_flush),
  .slot_vld   (slot_vld),
  .ret_n      (ret_n),
  .det_q      (det_q),
  .t1_q       (t1_q),
  .t2_q       (t2_q)
);

// File: tb/test_retire_sample_capture.sv
`timescale 1ns/1ps
module test_retire_sample_capture;
  localparam int W = 4, XLEN = 64, EVW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] slot_vld = '0, slot_taken = '0;
  logic [W*XLEN-1:0] slot_tgt = '0;
  logic [W*EVW-1:0] slot_evt = '0;
  logic rs_stall = 0, rs_drained = 0, rs_flush = 0, smp_strobe = 0;
  logic [1:0] csr_sel = '0;
  logic csr_we = 0;
  logic [XLEN-1:0] csr_wdata = '0, csr_rdata;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  retire_sample_capture #(.W(W), .XLEN(XLEN), .EVW(EVW)) i_retire_sample_capture (
    .clk, .rst_n, .slot_vld, .slot_taken, .slot_tgt, .slot_evt,
    .rs_stall, .rs_drained, .rs_flush, .smp_strobe,
    .csr_sel, .csr_we, .csr_wdata, .csr_rdata
  );

  function automatic logic [63:0] tgt_of(int cs, int i);
    return 64'hA000_0000_0000_0000 | (64'(cs) << 8) | 64'(i);
  endfunction
  function automatic logic [7:0] evt_of(int cs, int i);
    return 8'(cs * 7 + i * 37 + 1);
  endfunction

  // Reference: oldest-to-youngest scan written from the requirements.
  function automatic void ref_model(input logic [3:0] v, input logic [3:0] tk,
      input logic fl, input logic dr, input logic st, input int cs,
      output logic [63:0] det, output logic [63:0] t1, output logic [63:0] t2);
    int n = 0, cnt = 0, o1 = 0, o2 = 0, rs, bo;
    logic [7:0] cause = 0;
    t1 = 0; t2 = 0;
    while (n < 4 && v[n]) n++;
    for (int i = 0; i < n; i++)
      if (tk[i]) begin
        cnt++;
        if (cnt == 1) begin o1 = i + 1; t1 = tgt_of(cs, i); end
        if (cnt == 2) begin o2 = i + 1; t2 = tgt_of(cs, i); end
      end
    if (cnt > 7) cnt = 7;
    rs = (n > 0) ? 0 : fl ? 3 : dr ? 2 : st ? 1 : 2;
    bo = (n < 4 && rs != 2) ? n + 1 : 0;
    if (bo != 0) cause = evt_of(cs, n);
    det = 64'(rs) | (64'(cnt) << 2) | (64'(o1) << 5) | (64'(o2) << 8)
        | (64'(bo) << 11) | (64'(cause) << 14);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [63:0] d);
    csr_sel = s; #1; d = csr_rdata;
  endtask

  task automatic wr(input logic [1:0] s, input logic [63:0] d);
    @(negedge clk); csr_sel = s; csr_we = 1; csr_wdata = d;
    @(negedge clk); csr_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] d, e_det, e_t1, e_t2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    rd(0, d); check("R11 details", d, 0);
    rd(1, d); check("R11 target1", d, 0);
    rd(2, d); check("R11 target2", d, 0);

    // Exhaustive sweep: R1..R8
    for (int cs = 0; cs < 2048; cs++) begin
      logic [3:0] v, tk; logic fl, dr, st;
      v = cs[3:0]; tk = cs[7:4]; fl = cs[8]; dr = cs[9]; st = cs[10];
      @(negedge clk);
      slot_vld = v; slot_taken = tk; rs_flush = fl; rs_drained = dr; rs_stall = st;
      for (int i = 0; i < W; i++) begin
        slot_tgt[i*XLEN +: XLEN] = tgt_of(cs, i);
        slot_evt[i*EVW +: EVW] = evt_of(cs, i);
      end
      smp_strobe = 1;
      ref_model(v, tk, fl, dr, st, cs, e_det, e_t1, e_t2);
      @(negedge clk);
      smp_strobe = 0;
      slot_vld = ~v; slot_taken = ~tk; rs_flush = ~fl; rs_drained = ~dr;
      slot_tgt = ~slot_tgt; slot_evt = ~slot_evt;
      @(negedge clk);  // one edge without strobe: R8 hold
      rd(0, d); check("R1 R2 R4 R5 R6 R7 R8 details", d, e_det);
      rd(1, d); check("R1 R3 R8 target1", d, e_t1);
      rd(2, d); check("R3 R8 target2", d, e_t2);
    end

    // R9 writes and mask
    wr(0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(0, d); check("R9 details write mask", d, 64'h3F_FFFF);
    wr(1, 64'h1234_5678_9ABC_DEF0);
    rd(1, d); check("R9 target1 write", d, 64'h1234_5678_9ABC_DEF0);
    wr(2, 64'h0FED_CBA9_8765_4321);
    rd(2, d); check("R9 target2 write", d, 64'h0FED_CBA9_8765_4321);
    wr(3, 64'h5555_5555_5555_5555);
    rd(3, d); check("R9 sel3 reads zero", d, 0);
    rd(0, d); check("R9 sel3 no effect details", d, 64'h3F_FFFF);
    rd(1, d); check("R9 sel3 no effect target1", d, 64'h1234_5678_9ABC_DEF0);
    rd(2, d); check("R9 sel3 no effect target2", d, 64'h0FED_CBA9_8765_4321);

    // R10 strobe beats write in the same cycle
    @(negedge clk);
    slot_vld = 4'b0011; slot_taken = 4'b0010; rs_flush = 0; rs_drained = 0; rs_stall = 1;
    for (int i = 0; i < W; i++) begin
      slot_tgt[i*XLEN +: XLEN] = tgt_of(77, i);
      slot_evt[i*EVW +: EVW] = evt_of(77, i);
    end
    ref_model(4'b0011, 4'b0010, 0, 0, 1, 77, e_det, e_t1, e_t2);
    smp_strobe = 1; csr_we = 1; csr_sel = 2'd1; csr_wdata = 64'hDEAD_BEEF_0000_0001;
    @(negedge clk);
    smp_strobe = 0; csr_we = 0;
    rd(1, d); check("R10 target1 capture wins", d, e_t1);
    rd(0, d); check("R10 details capture wins", d, e_det);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule